// File: doc/BRIEF.md
# Write-Through Data Cache with Posted-Write Queue

This block sits between a processor's load/store port and a slow memory. It holds a direct-mapped store of single 32-bit words, indexed and tagged by the full 32-bit physical address, so any word in the address space can be resident. A load that finds its word resident completes in the cycle it is presented. A load that misses holds the processor in stall, lets every posted write reach memory, reads the one word, installs it as a valid line and then completes.

Stores never wait for memory. Each accepted store is copied into a small FIFO as an address, data and byte-enable entry. If the word is resident, the enabled bytes of the cached copy are also updated. A store to a word that is not resident leaves the cache untouched. The FIFO retires its entries in order through a valid/ready write handshake, at whatever pace memory accepts them. Memory therefore always ends up holding what the cache holds. The processor stalls on a store only when the FIFO is full.

A request is presented on `cpu_req` and must be held unchanged while `cpu_stall` is high. It completes in the first cycle in which `cpu_stall` is low at the clock edge.

Top module: `wtc_dcache`

## Requirements
- R1: After reset every line is invalid. `cpu_stall`, `mem_wr_valid` and `mem_rd_req` are low while the processor is idle, and the first load of any address misses and causes exactly one memory read.
- R2: A load whose word is resident completes with `cpu_stall` low in the cycle it is presented. It returns the cached word on `cpu_rdata` and issues no memory read.
- R3: A load miss holds `cpu_stall` high and raises `mem_rd_req` with `mem_rd_addr` equal to the load address. It keeps both steady until `mem_rd_ack`, installs `mem_rd_data` as a valid line, and then completes, returning that word.
- R4: Every accepted store enters the FIFO as one entry of address (the store address unchanged), data and byte enables. Entries appear on the memory write port in acceptance order, one per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high.
- R5: A store to a resident word replaces only the bytes whose enable is set, where `cpu_be[i]` covers data bits 8i+7 to 8i. A later load returns the merged word without a memory read.
- R6: A store to a word that is not resident does not allocate a line. A later load of that word misses and reads it from memory.
- R7: The FIFO holds four entries. Up to four stores are accepted without stall while memory accepts nothing. A store arriving with four entries pending keeps `cpu_stall` high until an entry has retired.
- R8: A load miss issues its memory read only when the FIFO is empty. `mem_rd_req` is never high while `mem_wr_valid` is high.
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_addr`, `mem_wr_data` and `mem_wr_be` stay unchanged.
- R10: Lines are direct mapped on address bits 10 to 2. Two addresses sharing those bits but differing above them evict each other, so alternate loads of them each miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables, bit i for bits 8i+7:8i |
| cpu_rdata | output | 32 | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Request must be held |
| mem_wr_valid | output | 1 | Write entry offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the offered write |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Write byte enables |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_ack | input | 1 | Read data returned this cycle |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_data | input | 32 | Read data |

## Verification
A wrong valid bit or tag shows on the very next load of that word. A stale hit returns the wrong `cpu_rdata` with no memory read, and a lost line costs an extra read and stall cycles. Both can be measured in the cycle of the load. A wrong FIFO pointer or count shows as entries leaving in the wrong order or with the wrong contents, or as a store stalled or not stalled at four pending entries, within the few cycles it takes memory to drain the queue. A bad byte merge shows as soon as the merged word is loaded back. A read issued early shows in the same cycle as `mem_rd_req` overlapping `mem_wr_valid`.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    MISS_IDLE  = 2'd0,
    MISS_DRAIN = 2'd1,
    MISS_READ  = 2'd2
  } miss_state_e;
endpackage

// File: rtl/wtc_post_fifo.sv
module wtc_post_fifo #(
  parameter int ENT_W = 68,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) ptr_inc = '0;
    else                        ptr_inc = p + PTR_W'(1);
  endfunction

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({do_push, do_pop})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_ptr_q] <= push_ent;
  end

  // The owner must never offer a store to a full queue.
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // An offered head that is not taken stays as it is.
  assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> (!empty && $stable(head)));
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int LINES  = 512,
  parameter int TAG_W  = 21,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES),
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lookup_idx,
  input  logic [TAG_W-1:0]  lookup_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [BE_W-1:0]   upd_be,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BE_W-1:0]  lane_we;

  assign hit = valid_q[lookup_idx] && (tag_q[lookup_idx] == lookup_tag);

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[wr_idx] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < BE_W; i++) begin
      lane_we[i] = fill_en || (upd_en && upd_be[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[wr_idx] <= fill_tag;
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic [7:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (lane_we[g]) lane_q[wr_idx] <= wr_data[8*g +: 8];
    end
    assign rd_data[8*g +: 8] = lane_q[lookup_idx];
  end

  // A freshly filled line answers the lookup that follows for the same word.
  assert_fill_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> ((lookup_idx != $past(wr_idx)) || (lookup_tag != $past(fill_tag)) || hit));

  // A fill and a store update never share one write cycle.
  assert_single_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && upd_en));
endmodule

// File: rtl/wtc_miss_ctrl.sv
module wtc_miss_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fifo_empty,
  input  logic              mem_rd_ack,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              fill_en
);
  miss_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_capture;

  always_comb begin
    state_d      = state_q;
    addr_capture = 1'b0;
    fill_en      = 1'b0;
    case (state_q)
      MISS_IDLE: begin
        if (miss_req) begin
          addr_capture = 1'b1;
          state_d      = fifo_empty ? MISS_READ : MISS_DRAIN;
        end
      end
      MISS_DRAIN: begin
        if (fifo_empty) state_d = MISS_READ;
      end
      MISS_READ: begin
        if (mem_rd_ack) begin
          fill_en = 1'b1;
          state_d = MISS_IDLE;
        end
      end
      default: state_d = MISS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MISS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (addr_capture) addr_q <= req_addr;
  end

  assign mem_rd_req  = (state_q == MISS_READ);
  assign mem_rd_addr = addr_q;

  // Reads start only once every posted write has left.
  assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> fifo_empty);

  // An unanswered read keeps its request and address.
  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
endmodule

// File: rtl/wtc_dcache.sv
module wtc_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 512,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [DATA_W/8-1:0] mem_wr_be,
  output logic              mem_rd_req,
  input  logic              mem_rd_ack,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFS_W = $clog2(BE_W);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int ENT_W = ADDR_W + DATA_W + BE_W;

  logic              rst_meta_q, rst_sync_q;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [ENT_W-1:0]  fifo_head;
  logic              store_take, upd_en, miss_req, fill_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  // Reset enters at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign store_take = cpu_req && cpu_we && !fifo_full;
  assign fifo_push  = store_take;
  assign upd_en     = store_take && lk_hit;
  assign miss_req   = cpu_req && !cpu_we && !lk_hit;
  assign cpu_stall  = cpu_req && (cpu_we ? fifo_full : !lk_hit);
  assign cpu_rdata  = lk_data;

  assign wr_idx  = fill_en ? mem_rd_addr[OFS_W +: IDX_W] : cpu_addr[OFS_W +: IDX_W];
  assign wr_data = fill_en ? mem_rd_data : cpu_wdata;

  assign mem_wr_valid = !fifo_empty;
  assign fifo_pop     = mem_wr_valid && mem_wr_ready;
  assign {mem_wr_addr, mem_wr_data, mem_wr_be} = fifo_head;

  wtc_line_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .lookup_idx(cpu_addr[OFS_W +: IDX_W]),
    .lookup_tag(cpu_addr[ADDR_W-1 -: TAG_W]),
    .hit       (lk_hit),
    .rd_data   (lk_data),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .upd_en    (upd_en),
    .upd_be    (cpu_be),
    .fill_en   (fill_en),
    .fill_tag  (mem_rd_addr[ADDR_W-1 -: TAG_W])
  );

  wtc_post_fifo #(
    .ENT_W(ENT_W),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .push    (fifo_push),
    .push_ent({cpu_addr, cpu_wdata, cpu_be}),
    .pop     (fifo_pop),
    .head    (fifo_head),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  wtc_miss_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_miss (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .miss_req   (miss_req),
    .req_addr   (cpu_addr),
    .fifo_empty (fifo_empty),
    .mem_rd_ack (mem_rd_ack),
    .mem_rd_req (mem_rd_req),
    .mem_rd_addr(mem_rd_addr),
    .fill_en    (fill_en)
  );

  // An accepted store is waiting on the memory write port one cycle later.
  assert_store_posted_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cpu_req && cpu_we && !cpu_stall) |=> mem_wr_valid);

  // The write port never overlaps an outstanding read.
  assert_port_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(mem_rd_req && mem_wr_valid));
endmodule

// File: tb/wtc_dcache_tb.sv
`timescale 1ns/1ps
module wtc_dcache_tb;
  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_be;
  logic        cpu_stall;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;
  logic        mem_rd_req, mem_rd_ack;
  logic [31:0] mem_rd_addr, mem_rd_data;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int rd_lat = 2;
  bit ready_ctl = 1'b1;

  logic [31:0] model [logic [31:0]];
  logic [31:0] wq_addr [$];
  logic [31:0] wq_data [$];
  logic [3:0]  wq_be   [$];

  wtc_dcache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] dflt(input logic [31:0] a);
    dflt = {a[15:0] ^ 16'h5a5a, a[31:16] ^ 16'h0f0f};
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    if (model.exists(k)) model_rd = model[k];
    else                 model_rd = dflt(k);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                        input logic [3:0] be);
    merge = old_w;
    for (int i = 0; i < 4; i++) if (be[i]) merge[8*i +: 8] = new_w[8*i +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Memory write sink: samples each cycle just after the falling edge.
  logic        prev_wait = 1'b0;
  logic [31:0] prev_a, prev_d;
  logic [3:0]  prev_b;
  initial begin
    mem_wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      mem_wr_ready = ready_ctl;
      #1;
      if (prev_wait && mem_wr_valid) begin
        chk(mem_wr_addr == prev_a && mem_wr_data == prev_d && mem_wr_be == prev_b,
            "R9", "held write entry", mem_wr_addr, prev_a);
      end
      if (mem_wr_valid && mem_wr_ready) begin
        wq_addr.push_back(mem_wr_addr);
        wq_data.push_back(mem_wr_data);
        wq_be.push_back(mem_wr_be);
        model[{mem_wr_addr[31:2], 2'b00}] = merge(model_rd(mem_wr_addr), mem_wr_data, mem_wr_be);
      end
      prev_wait = mem_wr_valid && !mem_wr_ready;
      prev_a = mem_wr_addr;
      prev_d = mem_wr_data;
      prev_b = mem_wr_be;
    end
  end

  // Memory read responder with a fixed latency.
  initial begin
    int lat_cnt;
    lat_cnt = 0;
    mem_rd_ack = 1'b0;
    mem_rd_data = '0;
    forever begin
      @(negedge clk);
      #1;
      if (mem_rd_req && mem_wr_valid)
        chk(1'b0, "R8", "read overlaps pending write", 32'd1, 32'd0);
      if (mem_rd_ack) begin
        mem_rd_ack = 1'b0;
      end else if (mem_rd_req) begin
        if (lat_cnt >= rd_lat) begin
          mem_rd_ack  = 1'b1;
          mem_rd_data = model_rd(mem_rd_addr);
          rd_cnt++;
          lat_cnt = 0;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    report();
  end

  task automatic do_load(input logic [31:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_be = 4'h0;
    stalls = 0;
    #1;
    while (cpu_stall) begin
      @(negedge clk); #1; stalls++;
    end
    d = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] w, input logic [3:0] be,
                          output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = w; cpu_be = be;
    stalls = 0;
    #1;
    while (cpu_stall) begin
      @(negedge clk); #1; stalls++;
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wait_drain();
    int n;
    n = 0;
    @(negedge clk); #1.5;
    while (mem_wr_valid && n < 200) begin
      @(negedge clk); #1.5; n++;
    end
    @(negedge clk);
  endtask

  task automatic clear_wq();
    wq_addr.delete(); wq_data.delete(); wq_be.delete();
  endtask

  task automatic t_reset();
    logic [31:0] d; int s; int r0;
    @(negedge clk); #1.5;
    chk(cpu_stall == 1'b0, "R1", "stall after reset", {31'd0, cpu_stall}, 32'd0);
    chk(mem_wr_valid == 1'b0, "R1", "write valid after reset", {31'd0, mem_wr_valid}, 32'd0);
    chk(mem_rd_req == 1'b0, "R1", "read req after reset", {31'd0, mem_rd_req}, 32'd0);
    r0 = rd_cnt;
    do_load(32'h0000_0000, d, s);
    chk(rd_cnt == r0 + 1, "R1", "first load reads once", rd_cnt - r0, 32'd1);
  endtask

  task automatic t_miss_then_hit();
    logic [31:0] a, d; int s; int r0;
    a = 32'h0000_1040;
    r0 = rd_cnt;
    do_load(a, d, s);
    chk(s > 0, "R3", "miss stalls", s, 32'd1);
    chk(rd_cnt == r0 + 1, "R3", "miss read count", rd_cnt - r0, 32'd1);
    chk(d == dflt(a), "R3", "miss data", d, dflt(a));
    r0 = rd_cnt;
    do_load(a, d, s);
    chk(s == 0, "R2", "hit without stall", s, 32'd0);
    chk(rd_cnt == r0, "R2", "hit reads nothing", rd_cnt - r0, 32'd0);
    chk(d == dflt(a), "R2", "hit data", d, dflt(a));
  endtask

  task automatic t_partial_store();
    logic [31:0] a, d, exp; int s; int r0;
    a = 32'h0000_1040;
    exp = merge(dflt(a), 32'hDEAD_BEEF, 4'b0101);
    clear_wq();
    do_store(a, 32'hDEAD_BEEF, 4'b0101, s);
    r0 = rd_cnt;
    do_load(a, d, s);
    chk(d == exp, "R5", "merged bytes", d, exp);
    chk(rd_cnt == r0, "R5", "merged load no read", rd_cnt - r0, 32'd0);
    wait_drain();
    chk(wq_addr.size() == 1 && wq_addr[0] == a && wq_data[0] == 32'hDEAD_BEEF && wq_be[0] == 4'b0101,
        "R4", "posted partial entry", wq_addr.size() > 0 ? wq_addr[0] : 32'hx, a);
  endtask

  task automatic t_store_miss();
    logic [31:0] b, d; int s; int r0;
    b = 32'h0000_2084;
    do_store(b, 32'h1234_5678, 4'hF, s);
    wait_drain();
    r0 = rd_cnt;
    do_load(b, d, s);
    chk(rd_cnt == r0 + 1, "R6", "store miss left no line", rd_cnt - r0, 32'd1);
    chk(d == 32'h1234_5678, "R6", "memory holds stored word", d, 32'h1234_5678);
  endtask

  task automatic t_fifo_full();
    int s; int s5;
    logic [31:0] base;
    base = 32'h0004_0000;
    clear_wq();
    ready_ctl = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      do_store(base + 32'(i * 4), 32'hA000_0000 + 32'(i), 4'hF, s);
      chk(s == 0, "R7", "store accepted below four", s, 32'd0);
    end
    fork
      do_store(base + 32'd16, 32'hA000_0004, 4'hF, s5);
      begin
        repeat (4) @(negedge clk);
        #1.5;
        chk(cpu_stall == 1'b1, "R7", "fifth store stalls", {31'd0, cpu_stall}, 32'd1);
        chk(mem_wr_addr == base, "R9", "head waits unchanged", mem_wr_addr, base);
        ready_ctl = 1'b1;
      end
    join
    chk(s5 >= 3, "R7", "fifth store stall cycles", s5, 32'd3);
    wait_drain();
    chk(wq_addr.size() == 5, "R4", "entries retired", wq_addr.size(), 32'd5);
    for (int i = 0; i < 5; i++) begin
      if (i < wq_addr.size())
        chk(wq_addr[i] == base + 32'(i * 4) && wq_data[i] == 32'hA000_0000 + 32'(i),
            "R4", "retire order", wq_addr[i], base + 32'(i * 4));
    end
  endtask

  task automatic t_drain_first();
    logic [31:0] c, dd, d; int s; int s2;
    c  = 32'h0005_0010;
    dd = 32'h0006_0020;
    clear_wq();
    ready_ctl = 1'b0;
    repeat (2) @(negedge clk);
    do_store(c, 32'hCAFE_F00D, 4'hF, s);
    fork
      do_load(dd, d, s2);
      begin
        repeat (6) @(negedge clk);
        #1.5;
        chk(mem_rd_req == 1'b0, "R8", "no read while write pending", {31'd0, mem_rd_req}, 32'd0);
        chk(cpu_stall == 1'b1, "R8", "load held during drain", {31'd0, cpu_stall}, 32'd1);
        ready_ctl = 1'b1;
      end
    join
    chk(d == dflt(dd), "R8", "load after drain data", d, dflt(dd));
    chk(wq_addr.size() == 1 && wq_addr[0] == c, "R8", "write retired first",
        wq_addr.size(), 32'd1);
  endtask

  task automatic t_conflict();
    logic [31:0] e, f, d; int s; int r0;
    e = 32'h0003_0100;
    f = 32'h0003_0900;
    do_load(e, d, s);
    r0 = rd_cnt;
    do_load(f, d, s);
    chk(rd_cnt == r0 + 1 && d == dflt(f), "R10", "same index other tag misses", d, dflt(f));
    r0 = rd_cnt;
    do_load(e, d, s);
    chk(rd_cnt == r0 + 1 && d == dflt(e), "R10", "evicted line misses again", d, dflt(e));
    r0 = rd_cnt;
    do_load(e, d, s);
    chk(rd_cnt == r0 && s == 0, "R10", "refilled line hits", rd_cnt - r0, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_partial_store();
    t_store_miss();
    t_fifo_full();
    t_drain_first();
    t_conflict();
    repeat (4) @(negedge clk);
    report();
  end
endmodule